// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block places a small register file on a simple single-cycle bus in front of a one-time-programmable fuse array. The array is modelled inside the block as bit storage that can only be burned from 0 to 1, and it starts blank at reset. Software selects a fuse word through an address field in the command register. It can then start a timed sense, which copies the fuse word into a readable result register. It can instead start a timed burn, which ORs a data word into the fuse word. A burn is allowed only while a 16-bit unlock key is present in the command register. The key is consumed by every burn attempt.

Each fuse word has a shadow copy that software reads at its own bus address. Writing a shadow word overrides it without touching the fuses. An override needs the same key and obeys the same write protection. A burn also ORs its data into the shadow copy.

Both sequences are timed in clock cycles from a timing register. The sequence is a relax period, then the strobe, then a second relax period. Busy stays high for the whole sequence. Failed or forbidden accesses set a sticky error flag, which software clears through a clear alias of the command register.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the command register (offset 0x00) reads 0, the timing register (offset 0x03) reads 0x0007100B, the sense result (offset 0x05) reads 0 and `strobe_o` is low.
- R2: The command register holds the unlock key in bits 31:16, the error flag in bit 9, busy in bit 8 and the fuse address in bits 6:0, with bit 7 and bits 15:10 reading 0. Offset 0x01 is a set alias that ORs the bits written 1 into the key, the address and the error flag. Offset 0x02 is a clear alias that clears only the bits written 1.
- R3: The error flag is sticky. Only a write of 1 to bit 9 through the clear alias clears it, and that clear works even while busy. A direct write to the command register leaves the flag unchanged.
- R4: While idle, a write with bit 0 set to the sense register (offset 0x04) starts a sense of the addressed word. Busy stays high until the sequence ends. In the first cycle with busy low, offset 0x05 holds the fuse word.
- R5: The timing register holds the sense strobe count S in bits 21:16, the relax count R in bits 15:12 and the burn strobe count P in bits 11:0. A sequence keeps busy high for R+1 cycles, then raises `strobe_o` for N+1-2(R+1) cycles (at least 1), then holds busy for R+1 more cycles. N is S for a sense and P for a burn.
- R6: While idle, a write to the burn-data register (offset 0x06) starts a burn only if the key field holds 0x3E77. At the end of the sequence the data is ORed into the fuse word, so burned bits never return to 0.
- R7: Every write to offset 0x06 while idle clears the key field to 0. If that write cannot burn because the key is missing, it sets the error flag and leaves the fuses unchanged.
- R8: Fuse word 3 is write-protected. A burn of word 3, or an override of its shadow, sets the error flag and changes nothing.
- R9: A write to offset 0x40+i overrides shadow word i when the key is present. The fuses are not changed and the key stays in place. Without the key the write sets the error flag and the shadow keeps its value.
- R10: The fuse address is bank*8 + word, for 32 words. A sense or burn with an address of 32 or more sets the error flag and does not raise busy.
- R11: While busy, writes to the command register, its set alias, the timing register, the sense register, the burn-data register and the shadow window are ignored. They set no error.
- R12: A burn ORs its data into the shadow copy of the word as well as the fuse word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| strobe_o | output | 1 | Fuse strobe, high during the strobe phase |

## Verification
The assertions assume that the bus holds each access for one cycle and that reads have no side effects. They also assume that the clear alias is the only bus path that can lower the error flag.

The stimulus issues one access per cycle and never overlaps a new start with a running sequence. The only exception is the deliberate writes made during busy to show that they are ignored. The timing values chosen give both normal strobes and the clamped one-cycle strobe.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int          REG_W    = 32;
    localparam logic [15:0] KEY_OPEN = 16'h3E77;
    localparam int          ERR_BIT  = 9;
    localparam int          BUSY_BIT = 8;

    localparam logic [7:0] OFF_CMD   = 8'h00;
    localparam logic [7:0] OFF_SET   = 8'h01;
    localparam logic [7:0] OFF_CLR   = 8'h02;
    localparam logic [7:0] OFF_TIME  = 8'h03;
    localparam logic [7:0] OFF_SENSE = 8'h04;
    localparam logic [7:0] OFF_RES   = 8'h05;
    localparam logic [7:0] OFF_BURN  = 8'h06;
    localparam logic [7:0] OFF_SHD   = 8'h40;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_STROBE,
        PH_POST
    } phase_e;

    typedef enum logic {
        OP_SENSE,
        OP_BURN
    } op_e;

    typedef struct packed {
        logic [15:0] key;
        logic        err;
        logic [6:0]  addr;
        logic [5:0]  t_sense;
        logic [3:0]  t_relax;
        logic [11:0] t_burn;
        logic [31:0] result;
        logic [31:0] burn_data;
        op_e         op;
    } regs_t;

endpackage

// File: rtl/otp_strobe_seq.sv
module otp_strobe_seq
    import otp_pkg::*;
#(
    parameter int CW = 12,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [RW-1:0] relax_i,
    input  logic [CW-1:0] span_i,
    output logic          busy_o,
    output logic          strobe_o,
    output logic          last_o
);

    localparam int CNT_W = CW + 1;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wid;
        logic [RW-1:0]    relax;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] total, ovh;

    always_comb begin
        seq_d  = seq_q;
        last_o = 1'b0;
        total  = {1'b0, span_i} + 1'b1;
        ovh    = (CNT_W'(relax_i) + 1'b1) << 1;
        case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.ph    = PH_PRE;
                    seq_d.cnt   = CNT_W'(relax_i);
                    seq_d.relax = relax_i;
                    seq_d.wid   = (total > ovh) ? (total - ovh) : CNT_W'(1);
                end
            end
            PH_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph  = PH_STROBE;
                    seq_d.cnt = seq_q.wid - 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph  = PH_POST;
                    seq_d.cnt = CNT_W'(seq_q.relax);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_POST: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph = PH_IDLE;
                    last_o   = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0, wid: '0, relax: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o   = (seq_q.ph != PH_IDLE);
    assign strobe_o = (seq_q.ph == PH_STROBE);

endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank #(
    parameter int NUM_WORDS = 32,
    parameter int DW        = 32,
    parameter int IDX_W     = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           burn_i,
    input  logic                           ovr_i,
    input  logic [IDX_W-1:0]               burn_idx_i,
    input  logic [DW-1:0]                  burn_data_i,
    input  logic [IDX_W-1:0]               ovr_idx_i,
    input  logic [DW-1:0]                  ovr_data_i,
    input  logic [IDX_W-1:0]               sense_idx_i,
    input  logic [IDX_W-1:0]               view_idx_i,
    output logic [DW-1:0]                  sense_o,
    output logic [DW-1:0]                  view_o,
    output logic [NUM_WORDS-1:0][DW-1:0]   fuse_all_o
);

    logic [DW-1:0] fuse_q [NUM_WORDS];
    logic [DW-1:0] shd_q  [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [DW-1:0] fuse_d, shd_d;
        logic          burn_hit, ovr_hit;

        always_comb begin
            burn_hit = burn_i && (burn_idx_i == IDX_W'(i));
            ovr_hit  = ovr_i && (ovr_idx_i == IDX_W'(i));
            fuse_d   = fuse_q[i];
            shd_d    = shd_q[i];
            if (burn_hit) begin
                fuse_d = fuse_q[i] | burn_data_i;
                shd_d  = shd_q[i] | burn_data_i;
            end else if (ovr_hit) begin
                shd_d = ovr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fuse_q[i] <= '0;
                shd_q[i]  <= '0;
            end else begin
                fuse_q[i] <= fuse_d;
                shd_q[i]  <= shd_d;
            end
        end

        assign fuse_all_o[i] = fuse_q[i];
    end

    assign sense_o = fuse_q[sense_idx_i];
    assign view_o  = shd_q[view_idx_i];

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int                   NUM_WORDS = 32,
    parameter logic [NUM_WORDS-1:0] LOCK_MASK = NUM_WORDS'(8)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel_i,
    input  logic        bus_wr_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        strobe_o
);

    localparam int         IDX_W = $clog2(NUM_WORDS);
    localparam logic [7:0] NW8   = 8'(NUM_WORDS);

    regs_t regs_d, regs_q;

    logic                           seq_start, seq_busy, seq_strobe, seq_last;
    logic [11:0]                    seq_span;
    logic                           burn_en, ovr_en, wr_en;
    logic                           addr_ok, addr_locked, key_ok;
    logic                           shd_hit, shd_locked;
    logic [IDX_W-1:0]               fuse_idx, shd_idx;
    logic [31:0]                    sense_word, view_word;
    logic [NUM_WORDS-1:0][31:0]     fuse_all;
    logic                           err_w;
    logic [15:0]                    key_w;

    assign wr_en       = bus_sel_i && bus_wr_i;
    assign fuse_idx    = regs_q.addr[IDX_W-1:0];
    assign addr_ok     = {1'b0, regs_q.addr} < NW8;
    assign addr_locked = LOCK_MASK[fuse_idx];
    assign key_ok      = (regs_q.key == KEY_OPEN);
    assign shd_hit     = (bus_addr_i >= OFF_SHD) && (bus_addr_i < (OFF_SHD + NW8));
    assign shd_idx     = IDX_W'(bus_addr_i - OFF_SHD);
    assign shd_locked  = LOCK_MASK[shd_idx];
    assign burn_en     = seq_last && (regs_q.op == OP_BURN);

    always_comb begin
        regs_d    = regs_q;
        seq_start = 1'b0;
        seq_span  = 12'(regs_q.t_sense);
        ovr_en    = 1'b0;

        if (wr_en && !seq_busy) begin
            case (bus_addr_i)
                OFF_CMD: begin
                    regs_d.key  = bus_wdata_i[31:16];
                    regs_d.addr = bus_wdata_i[6:0];
                end
                OFF_SET: begin
                    regs_d.key  = regs_q.key | bus_wdata_i[31:16];
                    regs_d.addr = regs_q.addr | bus_wdata_i[6:0];
                    if (bus_wdata_i[ERR_BIT]) begin
                        regs_d.err = 1'b1;
                    end
                end
                OFF_CLR: begin
                    regs_d.key  = regs_q.key & ~bus_wdata_i[31:16];
                    regs_d.addr = regs_q.addr & ~bus_wdata_i[6:0];
                end
                OFF_TIME: begin
                    regs_d.t_sense = bus_wdata_i[21:16];
                    regs_d.t_relax = bus_wdata_i[15:12];
                    regs_d.t_burn  = bus_wdata_i[11:0];
                end
                OFF_SENSE: begin
                    if (bus_wdata_i[0]) begin
                        if (addr_ok) begin
                            seq_start = 1'b1;
                            regs_d.op = OP_SENSE;
                        end else begin
                            regs_d.err = 1'b1;
                        end
                    end
                end
                OFF_BURN: begin
                    regs_d.key = '0;
                    if (key_ok && addr_ok && !addr_locked) begin
                        seq_start        = 1'b1;
                        seq_span         = regs_q.t_burn;
                        regs_d.op        = OP_BURN;
                        regs_d.burn_data = bus_wdata_i;
                    end else begin
                        regs_d.err = 1'b1;
                    end
                end
                default: begin
                    if (shd_hit) begin
                        if (key_ok && !shd_locked) begin
                            ovr_en = 1'b1;
                        end else begin
                            regs_d.err = 1'b1;
                        end
                    end
                end
            endcase
        end

        if (wr_en && (bus_addr_i == OFF_CLR) && bus_wdata_i[ERR_BIT]) begin
            regs_d.err = 1'b0;
        end

        if (seq_last && (regs_q.op == OP_SENSE)) begin
            regs_d.result = sense_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{key: '0, err: 1'b0, addr: '0,
                        t_sense: 6'd7, t_relax: 4'd1, t_burn: 12'd11,
                        result: '0, burn_data: '0, op: OP_SENSE};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFF_CMD:  bus_rdata_o = {regs_q.key, 6'b0, regs_q.err, seq_busy, 1'b0, regs_q.addr};
            OFF_TIME: bus_rdata_o = {10'b0, regs_q.t_sense, regs_q.t_relax, regs_q.t_burn};
            OFF_RES:  bus_rdata_o = regs_q.result;
            default: begin
                if (shd_hit) begin
                    bus_rdata_o = view_word;
                end
            end
        endcase
    end

    otp_strobe_seq #(.CW(12), .RW(4)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (seq_start),
        .relax_i  (regs_q.t_relax),
        .span_i   (seq_span),
        .busy_o   (seq_busy),
        .strobe_o (seq_strobe),
        .last_o   (seq_last)
    );

    otp_fuse_bank #(.NUM_WORDS(NUM_WORDS), .DW(REG_W), .IDX_W(IDX_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .burn_i      (burn_en),
        .ovr_i       (ovr_en),
        .burn_idx_i  (fuse_idx),
        .burn_data_i (regs_q.burn_data),
        .ovr_idx_i   (shd_idx),
        .ovr_data_i  (bus_wdata_i),
        .sense_idx_i (fuse_idx),
        .view_idx_i  (shd_idx),
        .sense_o     (sense_word),
        .view_o      (view_word),
        .fuse_all_o  (fuse_all)
    );

    assign strobe_o = seq_strobe;
    assign err_w    = regs_q.err;
    assign key_w    = regs_q.key;

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
    import otp_pkg::*;
#(
    parameter int NUM_WORDS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sel,
    input logic                       wr,
    input logic [7:0]                 addr,
    input logic                       clr_bit,
    input logic                       busy,
    input logic                       strobe,
    input logic                       last,
    input logic                       err,
    input logic [15:0]                key,
    input logic [NUM_WORDS-1:0][31:0] fuse_all
);

    AST_STROBE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);  // R5

    AST_BUSY_HELD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);  // R4

    AST_FUSE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((fuse_all & $past(fuse_all)) == $past(fuse_all)));  // R6

    AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && (addr == OFF_BURN) && !busy) |=> (key == 16'h0));  // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(sel && wr && (addr == OFF_CLR) && clr_bit)) |=> err);  // R3

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel_i),
    .wr       (bus_wr_i),
    .addr     (bus_addr_i),
    .clr_bit  (bus_wdata_i[9]),
    .busy     (seq_busy),
    .strobe   (seq_strobe),
    .last     (seq_last),
    .err      (err_w),
    .key      (key_w),
    .fuse_all (fuse_all)
);

// File: tb/otp_fuse_ctrl_bench.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic        chk = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        strobe;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    otp_fuse_ctrl u_otp_fuse_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .strobe_o    (strobe)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; chk = 1'b0; addr = a; wdata = d;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; chk = 1'b1; addr = a; wdata = '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic bus_idle();
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; chk = 1'b0;
    endtask

    // Poll the command register each cycle; count busy and strobe cycles.
    task automatic wait_op(input int exp_busy, input int exp_strobe, input string tag, input bit do_check);
        int nb = 0;
        int ns = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            sel = 1'b1; wr = 1'b0; chk = 1'b0; addr = 8'h00;
            #1;
            if (strobe) ns++;
            if (rdata[8]) nb++;
            else break;
        end
        if (do_check) begin
            check({tag, " busy cycles"}, 32'(nb), 32'(exp_busy));
            check({tag, " strobe cycles"}, 32'(ns), 32'(exp_strobe));
        end
    endtask

    // Monitor: compares each checked read against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sel && !wr && chk) begin
                if (exp_q.size() == 0) begin
                    check("scoreboard underflow", 32'h1, 32'h0);
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 strobe_o at reset", 32'(strobe), 32'h0);
        bus_rd(8'h00, 32'h0000_0000, "R1 command reset");
        bus_rd(8'h03, 32'h0007_100B, "R1 timing reset");
        bus_rd(8'h05, 32'h0000_0000, "R1 result reset");

        // R2 field layout and aliases
        bus_wr(8'h00, 32'h3E77_0005);
        bus_rd(8'h00, 32'h3E77_0005, "R2 command write");
        bus_wr(8'h01, 32'h0000_0200);
        bus_rd(8'h00, 32'h3E77_0205, "R2 set alias error");
        bus_wr(8'h02, 32'h0001_0001);
        bus_rd(8'h00, 32'h3E76_0204, "R2 clear alias key and addr");
        bus_wr(8'h02, 32'h0000_0200);
        bus_rd(8'h00, 32'h3E76_0004, "R3 clear alias error");
        bus_wr(8'h01, 32'h0000_0200);
        bus_wr(8'h00, 32'h0000_0000);
        bus_rd(8'h00, 32'h0000_0200, "R3 direct write keeps error");
        bus_wr(8'h02, 32'h0000_0200);

        // R6 burn with key, R7 key spent, R4 sense
        bus_wr(8'h00, 32'h3E77_000A);
        bus_wr(8'h06, 32'h0000_00F0);
        wait_op(12, 8, "R6 burn", 1'b1);
        bus_rd(8'h00, 32'h0000_000A, "R7 key cleared after burn");
        bus_wr(8'h04, 32'h0000_0001);
        wait_op(8, 4, "R4 sense", 1'b1);
        bus_rd(8'h05, 32'h0000_00F0, "R4 sense result");

        bus_wr(8'h00, 32'h3E77_000A);
        bus_wr(8'h06, 32'h0F00_0001);
        wait_op(12, 8, "R6 second burn", 1'b1);
        bus_wr(8'h04, 32'h0000_0001);
        wait_op(8, 4, "R4 sense", 1'b0);
        bus_rd(8'h05, 32'h0F00_00F1, "R6 bits accumulate");
        bus_rd(8'h4A, 32'h0F00_00F1, "R12 shadow follows burn");

        // R7 missing or wrong key
        bus_wr(8'h00, 32'h0000_000A);
        bus_wr(8'h06, 32'hFFFF_FFFF);
        bus_rd(8'h00, 32'h0000_020A, "R7 no key sets error");
        bus_wr(8'h04, 32'h0000_0001);
        wait_op(8, 4, "R7 sense", 1'b0);
        bus_rd(8'h05, 32'h0F00_00F1, "R7 fuses unchanged");
        bus_wr(8'h02, 32'h0000_0200);
        bus_wr(8'h00, 32'h3E76_000A);
        bus_wr(8'h06, 32'h0000_0100);
        bus_rd(8'h00, 32'h0000_020A, "R7 wrong key cleared and error");
        bus_wr(8'h02, 32'h0000_0200);

        // R8 protected word 3
        bus_wr(8'h00, 32'h3E77_0003);
        bus_wr(8'h06, 32'h0000_0001);
        bus_rd(8'h00, 32'h0000_0203, "R8 protected burn error");
        bus_wr(8'h02, 32'h0000_0200);
        bus_wr(8'h04, 32'h0000_0001);
        wait_op(8, 4, "R8 sense", 1'b0);
        bus_rd(8'h05, 32'h0000_0000, "R8 protected fuse unchanged");
        bus_wr(8'h00, 32'h3E77_0003);
        bus_wr(8'h43, 32'h0000_0055);
        bus_rd(8'h00, 32'h3E77_0203, "R8 protected override error");
        bus_rd(8'h43, 32'h0000_0000, "R8 protected shadow unchanged");
        bus_wr(8'h02, 32'h0000_0200);

        // R9 override
        bus_wr(8'h00, 32'h3E77_0005);
        bus_wr(8'h45, 32'h0000_A5A5);
        bus_rd(8'h45, 32'h0000_A5A5, "R9 override value");
        bus_rd(8'h00, 32'h3E77_0005, "R9 override keeps key");
        bus_wr(8'h04, 32'h0000_0001);
        wait_op(8, 4, "R9 sense", 1'b0);
        bus_rd(8'h05, 32'h0000_0000, "R9 fuse untouched by override");
        bus_wr(8'h00, 32'h0000_0005);
        bus_wr(8'h45, 32'h0000_0001);
        bus_rd(8'h00, 32'h0000_0205, "R9 override without key error");
        bus_rd(8'h45, 32'h0000_A5A5, "R9 shadow kept");
        bus_wr(8'h02, 32'h0000_0200);

        // R10 address range and bank/word mapping
        bus_wr(8'h00, 32'h0000_0028);
        bus_wr(8'h04, 32'h0000_0001);
        bus_rd(8'h00, 32'h0000_0228, "R10 sense out of range");
        bus_wr(8'h02, 32'h0000_0200);
        bus_wr(8'h00, 32'h3E77_0028);
        bus_wr(8'h06, 32'h0000_0001);
        bus_rd(8'h00, 32'h0000_0228, "R10 burn out of range");
        bus_wr(8'h02, 32'h0000_0200);
        bus_wr(8'h00, 32'h3E77_0017);
        bus_wr(8'h06, 32'h0000_1234);
        wait_op(12, 8, "R10 burn bank2 word7", 1'b0);
        bus_rd(8'h57, 32'h0000_1234, "R10 bank2 word7 shadow");

        // R11 writes during busy ignored
        bus_wr(8'h00, 32'h0000_000A);
        bus_wr(8'h04, 32'h0000_0001);
        bus_wr(8'h03, 32'h0000_0000);
        bus_wr(8'h00, 32'h3E77_0001);
        bus_wr(8'h06, 32'h0000_FFFF);
        bus_wr(8'h4A, 32'h0000_0000);
        wait_op(0, 0, "R11", 1'b0);
        bus_rd(8'h03, 32'h0007_100B, "R11 timing kept");
        bus_rd(8'h00, 32'h0000_000A, "R11 command kept no error");
        bus_rd(8'h05, 32'h0F00_00F1, "R11 sense result");
        bus_rd(8'h4A, 32'h0F00_00F1, "R11 shadow kept");

        // R5 programmable timing and clamped strobe
        bus_wr(8'h03, 32'h0014_301E);
        bus_rd(8'h03, 32'h0014_301E, "R5 timing layout");
        bus_wr(8'h04, 32'h0000_0001);
        wait_op(21, 13, "R5 long sense", 1'b1);
        bus_wr(8'h00, 32'h3E77_000A);
        bus_wr(8'h06, 32'h0000_0000);
        wait_op(31, 23, "R5 long burn", 1'b1);
        bus_wr(8'h03, 32'h0002_300B);
        bus_wr(8'h04, 32'h0000_0001);
        wait_op(9, 1, "R5 clamped strobe", 1'b1);

        bus_idle();
        repeat (4) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule